// File: doc/BRIEF.md
# Phrase List Playback Sequencer

This block plays a spoken message that is built from several pieces. A host selects one of 31 lists by a 5-bit number. Each list holds up to eight ordered steps. A step either names a stored phrase or asks for a stretch of quiet. A stored phrase is a contiguous range of byte addresses in an external sample memory, and each phrase has its own clock divider. The divider sets how many system clocks each byte is held on the output. A quiet step holds the output at mid-scale for a whole number of fixed time units and reads no memory at all.

Both tables are small register arrays with write ports. They are filled before playback. A new play request abandons whatever is in progress and starts the new list at once. A stop request, or a play request for list 0, returns the block to rest. The block only sequences and paces the memory reads. Sample decoding and the analog stage sit outside it.

Top module: `phrase_list_seq`

## Requirements
- R1: A list step is 7 bits: bit 6 is the end marker, bit 5 selects quiet (1) or phrase (0), and bits 4:0 hold the phrase number or the quiet length. Steps run from slot 0 upward. A list finishes on the first step whose end marker is set (one cycle for that check) or right after slot 7 completes. After reset every step of every list carries the end marker.
- R2: A phrase step reads every address from its start address to its end address inclusive, one `mem_rd` pulse per sample period. `mem_rdata` is expected one cycle after the pulse. Two cycles after the pulse, `sample_out` shows that byte shifted left by two bits.
- R3: Divider codes 0 to 6 give periods of 1024, 768, 640, 512, 384, 320 and 256 clocks. Code 7 gives 256. Consecutive reads of one phrase are exactly one period apart.
- R4: A quiet step of length n lasts n × SIL_UNIT clocks. During it `sample_out` holds 512 and `mem_rd` stays low. A quiet length of 0 lasts no time.
- R5: A play request naming a list from 1 to 31 abandons the current list and starts the named list from slot 0. `busy` rises in the next cycle and stays high across the switch.
- R6: A stop request, or a play request naming list 0, ends playback. From the next cycle `busy` is low, `sample_out` is 512 and no read follows. When stop and play arrive in the same cycle, stop wins.
- R7: `busy` is high for exactly the sum of one cycle plus the step length for each step played, plus one cycle when the list ends on an end marker.
- R8: While `busy` is low, `sample_out` is 512 and `mem_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| play_req | input | 1 | One-cycle play request |
| play_list | input | 5 | List number for play_req (0 means stop) |
| stop_req | input | 1 | One-cycle stop request |
| lt_we | input | 1 | List table write enable |
| lt_list | input | 5 | List table write: list number |
| lt_slot | input | 3 | List table write: slot number |
| lt_entry | input | 7 | List table write: step word |
| pt_we | input | 1 | Phrase table write enable |
| pt_idx | input | 5 | Phrase table write: phrase number |
| pt_start | input | MEM_AW | Phrase table write: first byte address |
| pt_end | input | MEM_AW | Phrase table write: last byte address |
| pt_code | input | 3 | Phrase table write: divider code |
| mem_rd | output | 1 | Sample memory read strobe |
| mem_addr | output | MEM_AW | Sample memory address |
| mem_rdata | input | 8 | Sample byte, valid one cycle after mem_rd |
| sample_out | output | 10 | Sample code to the output stage |
| busy | output | 1 | High while a list is being played |

## Verification
Some rules hold on every cycle, and the bound checker watches them. At rest the output is mid-scale and no reads happen. A stop clears `busy` in the next cycle. A valid play request raises `busy` in the next cycle. Reads are never back to back, because every divider is at least 256.

Other behaviour only shows up over whole scenarios, so the directed tests cover it:
- the exact `busy` length for phrase, quiet and zero-length steps;
- a full eight-step list, and a list cut short by an end marker;
- read addresses and spacing for every divider code;
- byte-to-output alignment;
- silence in the middle of a list;
- the abandon and stop paths.

// File: rtl/pls_pkg.sv
package pls_pkg;

    localparam int LIST_AW   = 5;
    localparam int NUM_LISTS = 2 ** LIST_AW;
    localparam int SLOTS     = 8;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int VAL_W     = 5;
    localparam int NUM_PHR   = 2 ** VAL_W;
    localparam int ENTRY_W   = VAL_W + 2;
    localparam int CODE_W    = 3;
    localparam int DIV_W     = 11;
    localparam int BYTE_W    = 8;
    localparam int OUT_W     = 10;
    localparam logic [OUT_W-1:0] MID_CODE = OUT_W'(512);

    // One list step: end marker, quiet select, phrase number or quiet length
    typedef struct packed {
        logic             last;
        logic             quiet;
        logic [VAL_W-1:0] val;
    } step_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PHRASE,
        ST_QUIET
    } seq_state_t;

    // Sample period in clocks for a divider code
    function automatic logic [DIV_W-1:0] period_of(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    period_of = DIV_W'(1024);
            3'd1:    period_of = DIV_W'(768);
            3'd2:    period_of = DIV_W'(640);
            3'd3:    period_of = DIV_W'(512);
            3'd4:    period_of = DIV_W'(384);
            3'd5:    period_of = DIV_W'(320);
            default: period_of = DIV_W'(256);
        endcase
    endfunction

endpackage

// File: rtl/pls_list_table.sv
module pls_list_table
    import pls_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [LIST_AW-1:0] wr_list,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  step_t              wr_step,
    input  logic [LIST_AW-1:0] rd_list,
    input  logic [SLOT_W-1:0]  rd_slot,
    output step_t              rd_step
);

    step_t tab [NUM_LISTS][SLOTS];

    for (genvar gl = 0; gl < NUM_LISTS; gl++) begin : g_list
        for (genvar gs = 0; gs < SLOTS; gs++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    tab[gl][gs] <= '{last: 1'b1, quiet: 1'b0, val: '0};
                end else if (we && wr_list == LIST_AW'(gl) && wr_slot == SLOT_W'(gs)) begin
                    tab[gl][gs] <= wr_step;
                end
            end
        end
    end

    assign rd_step = tab[rd_list][rd_slot];

endmodule

// File: rtl/pls_phrase_table.sv
module pls_phrase_table
    import pls_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [VAL_W-1:0]  wr_idx,
    input  logic [MEM_AW-1:0] wr_start,
    input  logic [MEM_AW-1:0] wr_end,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [VAL_W-1:0]  rd_idx,
    output logic [MEM_AW-1:0] rd_start,
    output logic [MEM_AW-1:0] rd_end,
    output logic [CODE_W-1:0] rd_code
);

    logic [MEM_AW-1:0] start_r [NUM_PHR];
    logic [MEM_AW-1:0] end_r   [NUM_PHR];
    logic [CODE_W-1:0] code_r  [NUM_PHR];

    for (genvar gp = 0; gp < NUM_PHR; gp++) begin : g_phr
        always_ff @(posedge clk) begin
            if (rst) begin
                start_r[gp] <= '0;
                end_r[gp]   <= '0;
                code_r[gp]  <= '0;
            end else if (we && wr_idx == VAL_W'(gp)) begin
                start_r[gp] <= wr_start;
                end_r[gp]   <= wr_end;
                code_r[gp]  <= wr_code;
            end
        end
    end

    assign rd_start = start_r[rd_idx];
    assign rd_end   = end_r[rd_idx];
    assign rd_code  = code_r[rd_idx];

endmodule

// File: rtl/pls_tick_timer.sv
module pls_tick_timer #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] limit,
    output logic          at_zero,
    output logic          wrap
);

    logic [CW-1:0] cnt_q;

    assign at_zero = (cnt_q == '0);
    assign wrap    = en && (cnt_q == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= wrap ? '0 : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/phrase_list_seq.sv
module phrase_list_seq
    import pls_pkg::*;
#(
    parameter int MEM_AW   = 16,
    parameter int SIL_UNIT = 131072
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               play_req,
    input  logic [LIST_AW-1:0] play_list,
    input  logic               stop_req,
    input  logic               lt_we,
    input  logic [LIST_AW-1:0] lt_list,
    input  logic [SLOT_W-1:0]  lt_slot,
    input  logic [ENTRY_W-1:0] lt_entry,
    input  logic               pt_we,
    input  logic [VAL_W-1:0]   pt_idx,
    input  logic [MEM_AW-1:0]  pt_start,
    input  logic [MEM_AW-1:0]  pt_end,
    input  logic [CODE_W-1:0]  pt_code,
    output logic               mem_rd,
    output logic [MEM_AW-1:0]  mem_addr,
    input  logic [BYTE_W-1:0]  mem_rdata,
    output logic [OUT_W-1:0]   sample_out,
    output logic               busy
);

    localparam int MAX_LIM = (SIL_UNIT > 1024) ? SIL_UNIT : 1024;
    localparam int CW      = $clog2(MAX_LIM + 1);

    seq_state_t         state_q, state_d;
    logic [LIST_AW-1:0] list_q, list_d;
    logic [SLOT_W-1:0]  slot_q, slot_d;
    logic [MEM_AW-1:0]  ptr_q, ptr_d;
    logic [MEM_AW-1:0]  stop_q, stop_d;
    logic [DIV_W-1:0]   per_q, per_d;
    logic [VAL_W-1:0]   left_q, left_d;
    logic               pend_q;
    logic [OUT_W-1:0]   samp_q;

    step_t             cur_step;
    logic [MEM_AW-1:0] ph_start, ph_end;
    logic [CODE_W-1:0] ph_code;
    logic              tm_clr, tm_en, tm_zero, tm_wrap;
    logic [CW-1:0]     tm_limit;
    logic              cmd_stop, cmd_play;

    pls_list_table u_lists (
        .clk     (clk),
        .rst     (rst),
        .we      (lt_we),
        .wr_list (lt_list),
        .wr_slot (lt_slot),
        .wr_step (step_t'(lt_entry)),
        .rd_list (list_q),
        .rd_slot (slot_q),
        .rd_step (cur_step)
    );

    pls_phrase_table #(.MEM_AW(MEM_AW)) u_phrases (
        .clk      (clk),
        .rst      (rst),
        .we       (pt_we),
        .wr_idx   (pt_idx),
        .wr_start (pt_start),
        .wr_end   (pt_end),
        .wr_code  (pt_code),
        .rd_idx   (cur_step.val),
        .rd_start (ph_start),
        .rd_end   (ph_end),
        .rd_code  (ph_code)
    );

    assign tm_clr   = (state_q == ST_FETCH);
    assign tm_en    = (state_q == ST_PHRASE) || (state_q == ST_QUIET);
    assign tm_limit = (state_q == ST_QUIET) ? CW'(SIL_UNIT) : CW'(per_q);

    pls_tick_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tm_clr),
        .en      (tm_en),
        .limit   (tm_limit),
        .at_zero (tm_zero),
        .wrap    (tm_wrap)
    );

    assign cmd_stop = stop_req || (play_req && play_list == '0);
    assign cmd_play = play_req && (play_list != '0) && !stop_req;

    always_comb begin
        state_d = state_q;
        list_d  = list_q;
        slot_d  = slot_q;
        ptr_d   = ptr_q;
        stop_d  = stop_q;
        per_d   = per_q;
        left_d  = left_q;

        // step_done: move to the next slot or finish after the last one
        case (state_q)
            ST_FETCH: begin
                if (cur_step.last) begin
                    state_d = ST_IDLE;
                end else if (cur_step.quiet && cur_step.val == '0) begin
                    if (slot_q == SLOT_W'(SLOTS - 1)) state_d = ST_IDLE;
                    else slot_d = slot_q + SLOT_W'(1);
                end else if (cur_step.quiet) begin
                    state_d = ST_QUIET;
                    left_d  = cur_step.val;
                end else begin
                    state_d = ST_PHRASE;
                    ptr_d   = ph_start;
                    stop_d  = ph_end;
                    per_d   = period_of(ph_code);
                end
            end
            ST_PHRASE: begin
                if (tm_wrap) begin
                    if (ptr_q == stop_q) begin
                        if (slot_q == SLOT_W'(SLOTS - 1)) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_FETCH;
                            slot_d  = slot_q + SLOT_W'(1);
                        end
                    end else begin
                        ptr_d = ptr_q + MEM_AW'(1);
                    end
                end
            end
            ST_QUIET: begin
                if (tm_wrap) begin
                    if (left_q == VAL_W'(1)) begin
                        if (slot_q == SLOT_W'(SLOTS - 1)) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_FETCH;
                            slot_d  = slot_q + SLOT_W'(1);
                        end
                    end else begin
                        left_d = left_q - VAL_W'(1);
                    end
                end
            end
            default: ;
        endcase

        if (cmd_stop) begin
            state_d = ST_IDLE;
        end else if (cmd_play) begin
            state_d = ST_FETCH;
            list_d  = play_list;
            slot_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            list_q  <= '0;
            slot_q  <= '0;
            ptr_q   <= '0;
            stop_q  <= '0;
            per_q   <= DIV_W'(256);
            left_q  <= '0;
            pend_q  <= 1'b0;
            samp_q  <= MID_CODE;
        end else begin
            state_q <= state_d;
            list_q  <= list_d;
            slot_q  <= slot_d;
            ptr_q   <= ptr_d;
            stop_q  <= stop_d;
            per_q   <= per_d;
            left_q  <= left_d;
            pend_q  <= mem_rd && (state_d == ST_PHRASE);
            if (state_d != ST_PHRASE) begin
                samp_q <= MID_CODE;
            end else if (pend_q) begin
                samp_q <= {mem_rdata, {(OUT_W - BYTE_W){1'b0}}};
            end
        end
    end

    assign mem_rd     = (state_q == ST_PHRASE) && tm_zero;
    assign mem_addr   = ptr_q;
    assign sample_out = samp_q;
    assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/pls_checker.sv
module pls_checker
    import pls_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               play_req,
    input logic [LIST_AW-1:0] play_list,
    input logic               stop_req,
    input logic               mem_rd,
    input logic [OUT_W-1:0]   sample_out,
    input logic               busy
);

    // R6: a stop leaves the block at rest one cycle later
    p_stop_halts_r6: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> !busy);

    // R5: a valid play request makes the block busy one cycle later
    p_play_starts_r5: assert property (@(posedge clk) disable iff (rst)
        (play_req && play_list != '0 && !stop_req) |=> busy);

    // R8: at rest the output sits at mid-scale
    p_idle_mid_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sample_out == MID_CODE);

    // R8: at rest no memory read is issued
    p_idle_no_read_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd);

    // R3: every period is at least 256 clocks, so reads never come back to back
    p_read_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

endmodule

bind phrase_list_seq pls_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .play_req   (play_req),
    .play_list  (play_list),
    .stop_req   (stop_req),
    .mem_rd     (mem_rd),
    .sample_out (sample_out),
    .busy       (busy)
);

// File: tb/phrase_list_seq_tb.sv
`timescale 1ns/1ps
module phrase_list_seq_tb;
    import pls_pkg::*;

    localparam int MAW = 12;
    localparam int SU  = 64;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               play_req = 1'b0;
    logic [LIST_AW-1:0] play_list = '0;
    logic               stop_req = 1'b0;
    logic               lt_we = 1'b0;
    logic [LIST_AW-1:0] lt_list = '0;
    logic [SLOT_W-1:0]  lt_slot = '0;
    logic [ENTRY_W-1:0] lt_entry = '0;
    logic               pt_we = 1'b0;
    logic [VAL_W-1:0]   pt_idx = '0;
    logic [MAW-1:0]     pt_start = '0;
    logic [MAW-1:0]     pt_end = '0;
    logic [CODE_W-1:0]  pt_code = '0;
    logic               mem_rd;
    logic [MAW-1:0]     mem_addr;
    logic [BYTE_W-1:0]  mem_rdata = '0;
    logic [OUT_W-1:0]   sample_out;
    logic               busy;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    phrase_list_seq #(.MEM_AW(MAW), .SIL_UNIT(SU)) u_dut (
        .clk(clk), .rst(rst), .play_req(play_req), .play_list(play_list),
        .stop_req(stop_req), .lt_we(lt_we), .lt_list(lt_list), .lt_slot(lt_slot),
        .lt_entry(lt_entry), .pt_we(pt_we), .pt_idx(pt_idx), .pt_start(pt_start),
        .pt_end(pt_end), .pt_code(pt_code), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .sample_out(sample_out), .busy(busy)
    );

    function automatic logic [7:0] pat(input logic [MAW-1:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

    // Negedge monitor
    int m_busy, m_rd, m_serr, m_gmin, m_gmax, m_last, cyc;
    int m_log [16];
    logic p1_v = 1'b0, p2_v = 1'b0;
    logic [MAW-1:0] p1_a = '0, p2_a = '0;

    always @(negedge clk) begin
        cyc++;
        if (busy) m_busy++;
        if (p2_v && busy && sample_out !== {pat(p2_a), 2'b00}) m_serr++;
        p2_v = p1_v; p2_a = p1_a;
        p1_v = mem_rd; p1_a = mem_addr;
        if (mem_rd) begin
            if (m_rd > 0) begin
                if (cyc - m_last < m_gmin) m_gmin = cyc - m_last;
                if (cyc - m_last > m_gmax) m_gmax = cyc - m_last;
            end
            m_last = cyc;
            if (m_rd < 16) m_log[m_rd] = int'(mem_addr);
            m_rd++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        m_busy = 0; m_rd = 0; m_serr = 0; m_gmin = 1000000; m_gmax = 0;
    endtask

    task automatic wr_step(input int l, input int s, input bit last, input bit q, input int v);
        @(negedge clk); #1;
        lt_we = 1'b1; lt_list = LIST_AW'(l); lt_slot = SLOT_W'(s);
        lt_entry = {last, q, VAL_W'(v)};
        @(negedge clk); #1;
        lt_we = 1'b0;
    endtask

    task automatic wr_phr(input int idx, input int st, input int en, input int code);
        @(negedge clk); #1;
        pt_we = 1'b1; pt_idx = VAL_W'(idx); pt_start = MAW'(st);
        pt_end = MAW'(en); pt_code = CODE_W'(code);
        @(negedge clk); #1;
        pt_we = 1'b0;
    endtask

    task automatic start_play(input int l);
        @(negedge clk); #1;
        play_req = 1'b1; play_list = LIST_AW'(l);
        clear_mon();
        @(negedge clk); #1;
        play_req = 1'b0;
    endtask

    task automatic wait_idle();
        do begin @(negedge clk); #1; end while (busy);
    endtask

    task automatic t_reset();
        chk("R8 reset busy", int'(busy), 0);
        chk("R8 reset sample", int'(sample_out), 512);
        chk("R8 reset mem_rd", int'(mem_rd), 0);
    endtask

    task automatic t_single_phrase();
        wr_phr(2, 10, 12, 0);
        wr_step(1, 0, 0, 0, 2);
        start_play(1);
        wait_idle();
        chk("R7 single busy length", m_busy, 3 * 1024 + 2);
        chk("R2 read count", m_rd, 3);
        chk("R2 first addr", m_log[0], 10);
        chk("R2 last addr", m_log[2], 12);
        chk("R3 gap code0", m_gmin, 1024);
        chk("R2 byte alignment errors", m_serr, 0);
    endtask

    task automatic t_div_codes();
        int per [8] = '{1024, 768, 640, 512, 384, 320, 256, 256};
        for (int c = 0; c < 8; c++) begin
            wr_phr(3, 100, 101, c);
            wr_step(2, 0, 0, 0, 3);
            start_play(2);
            wait_idle();
            chk($sformatf("R3 gap min code%0d", c), m_gmin, per[c]);
            chk($sformatf("R3 gap max code%0d", c), m_gmax, per[c]);
            chk($sformatf("R7 busy code%0d", c), m_busy, 2 * per[c] + 2);
        end
    endtask

    task automatic t_quiet_mix();
        wr_phr(2, 10, 12, 6);
        wr_phr(4, 20, 20, 3);
        wr_step(3, 0, 0, 0, 2);
        wr_step(3, 1, 0, 1, 3);
        wr_step(3, 2, 0, 0, 4);
        start_play(3);
        repeat (799) begin @(negedge clk); #1; end
        chk("R4 quiet sample mid", int'(sample_out), 512);
        chk("R4 no reads in quiet", m_rd, 3);
        wait_idle();
        chk("R7 mixed busy", m_busy, 769 + 193 + 513 + 1);
        chk("R2 mixed reads", m_rd, 4);
        chk("R2 mixed last addr", m_log[3], 20);
        chk("R2 mixed alignment", m_serr, 0);
    endtask

    task automatic t_full_list();
        for (int s = 0; s < 8; s++) wr_step(4, s, 0, 1, 1);
        start_play(4);
        wait_idle();
        chk("R1 eight steps no end marker", m_busy, 8 * (1 + SU));
        chk("R4 quiet no reads", m_rd, 0);
    endtask

    task automatic t_end_marker();
        wr_phr(2, 10, 12, 0);
        wr_step(6, 0, 0, 1, 1);
        wr_step(6, 1, 1, 0, 0);
        wr_step(6, 2, 0, 0, 2);
        start_play(6);
        wait_idle();
        chk("R1 end marker stops list", m_busy, SU + 2);
        chk("R1 step after marker unread", m_rd, 0);
        start_play(9);
        wait_idle();
        chk("R1 unwritten list", m_busy, 1);
    endtask

    task automatic t_zero_quiet();
        wr_step(7, 0, 0, 1, 0);
        wr_step(7, 1, 0, 1, 2);
        start_play(7);
        wait_idle();
        chk("R4 zero-length quiet", m_busy, 1 + (1 + 2 * SU) + 1);
    endtask

    task automatic t_abort();
        start_play(1);
        repeat (100) begin @(negedge clk); #1; end
        chk("R5 busy before switch", int'(busy), 1);
        start_play(6);
        wait_idle();
        chk("R5 restarted list length", m_busy, SU + 2);
        chk("R5 old list no reads", m_rd, 0);
    endtask

    task automatic t_stop(input bit by_code);
        start_play(1);
        repeat (200) begin @(negedge clk); #1; end
        if (by_code) begin play_req = 1'b1; play_list = '0; end
        else stop_req = 1'b1;
        @(negedge clk); #1;
        play_req = 1'b0; stop_req = 1'b0;
        chk(by_code ? "R6 list0 busy" : "R6 stop busy", int'(busy), 0);
        chk(by_code ? "R6 list0 sample" : "R6 stop sample", int'(sample_out), 512);
        clear_mon();
        repeat (2100) begin @(negedge clk); #1; end
        chk(by_code ? "R6 list0 no reads" : "R6 stop no reads", m_rd, 0);
    endtask

    task automatic t_stop_wins();
        start_play(1);
        repeat (50) begin @(negedge clk); #1; end
        play_req = 1'b1; play_list = LIST_AW'(6); stop_req = 1'b1;
        @(negedge clk); #1;
        play_req = 1'b0; stop_req = 1'b0;
        chk("R6 stop beats play", int'(busy), 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        t_reset();
        t_single_phrase();
        t_div_codes();
        t_quiet_mix();
        t_full_list();
        t_end_marker();
        t_zero_quiet();
        t_abort();
        t_stop(1'b0);
        t_stop(1'b1);
        t_stop_wins();
        finish_run();
    end

endmodule